// File: doc/BRIEF.md
# Quaternary Digit Logic Operator Unit

This block applies one selectable radix-4 logic operator, digit by digit, to two operand vectors. Each operand holds `N` quaternary digits, and each digit is a 2-bit binary code for one of the levels 0 to 3. A 4-bit operation code picks the operator. The operators are:

- the two-input minimum and maximum;
- the single-input complement, bit exchange, inward inverter and outward inverter;
- compound forms, in which a bit exchange or one of the inverters is applied to the output of minimum or maximum.

The combinational result can pass through an output register chosen by a parameter. By default the register is present, so every result appears one clock after its inputs. An operation code outside the defined set gives an all-zero result and raises a flag that goes out with that result.

Top module: `qdigit_logic_unit`

## Requirements
- R1: Digit i of each operand and of the result sits in bits [2i+1:2i], digit 0 at the least significant pair, and its 2-bit value equals the logic level 0..3.
- R2: Code 0 gives each result digit as the smaller of the two operand digits.
- R3: Code 1 gives each result digit as the larger of the two operand digits.
- R4: Code 2 gives each result digit as 3 minus the digit of operand A.
- R5: Code 3 swaps the two bits of each digit of A, so 1 and 2 trade places and 0 and 3 stay as they are.
- R6: Code 4 applies the inward inverter to A. It takes 3 minus the digit, then turns a 3 into 2 and a 0 into 1.
- R7: Code 5 applies the outward inverter to A. It takes 3 minus the digit, then turns a 2 into 3 and a 1 into 0.
- R8: Codes 6 and 7 bit-swap the minimum and the maximum, in that order.
- R9: Codes 8 and 9 apply the inward inverter of R6 to the minimum and the maximum, in that order.
- R10: Codes 10 and 11 apply the outward inverter of R7 to the minimum and the maximum, in that order.
- R11: Codes 12 to 15 give an all-zero result with the illegal flag at 1. Codes 0 to 11 give the flag at 0.
- R12: Codes 2 to 5 ignore operand B completely.
- R13: With the output register present, the result and the flag take their values one clock after the inputs. An active-low reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset, clears the result and the flag |
| op_a | input | 2*N | Operand A, packed quaternary digits |
| op_b | input | 2*N | Operand B, packed quaternary digits |
| op_sel | input | 4 | Operation code |
| result | output | 2*N | Packed result digits |
| bad_op | output | 1 | High when the operation code is not one of 0..11 |

## Verification
With the default output register, both the result and the flag are due one clock edge after the operands and the code are applied. The bench drives the inputs on a falling edge, lets one rising edge capture them and compares at the next falling edge, so each value is read half a period after it was registered. Every operation code sees all sixteen digit pairs, and each digit lane gets a different rotation of those pairs. For the single-input codes each vector is applied a second time with operand B inverted, and that result must match the first.

// File: rtl/qdigit_logic_unit.sv
module qdigit_logic_unit #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*N-1:0] op_a,
  input  logic [2*N-1:0] op_b,
  input  logic [3:0]     op_sel,
  output logic [2*N-1:0] result,
  output logic           bad_op
);
  localparam int W = 2 * N;

  localparam logic [2:0] P_NONE = 3'd0;
  localparam logic [2:0] P_CMP  = 3'd1;
  localparam logic [2:0] P_SWAP = 3'd2;
  localparam logic [2:0] P_INW  = 3'd3;
  localparam logic [2:0] P_OUTW = 3'd4;

  localparam logic [1:0] B_MIN = 2'd0;
  localparam logic [1:0] B_MAX = 2'd1;
  localparam logic [1:0] B_A   = 2'd2;

  logic [1:0]   base_sel;
  logic [2:0]   post_sel;
  logic         legal;
  logic [W-1:0] res_d;

  always_comb begin
    base_sel = B_MIN;
    post_sel = P_NONE;
    legal    = 1'b1;
    case (op_sel)
      4'd0:  begin base_sel = B_MIN; post_sel = P_NONE; end
      4'd1:  begin base_sel = B_MAX; post_sel = P_NONE; end
      4'd2:  begin base_sel = B_A;   post_sel = P_CMP;  end
      4'd3:  begin base_sel = B_A;   post_sel = P_SWAP; end
      4'd4:  begin base_sel = B_A;   post_sel = P_INW;  end
      4'd5:  begin base_sel = B_A;   post_sel = P_OUTW; end
      4'd6:  begin base_sel = B_MIN; post_sel = P_SWAP; end
      4'd7:  begin base_sel = B_MAX; post_sel = P_SWAP; end
      4'd8:  begin base_sel = B_MIN; post_sel = P_INW;  end
      4'd9:  begin base_sel = B_MAX; post_sel = P_INW;  end
      4'd10: begin base_sel = B_MIN; post_sel = P_OUTW; end
      4'd11: begin base_sel = B_MAX; post_sel = P_OUTW; end
      default: legal = 1'b0;
    endcase
  end

  for (genvar g = 0; g < N; g++) begin : g_digit
    logic [1:0] a, b, lo, hi, base, post;
    assign a  = op_a[2*g +: 2];
    assign b  = op_b[2*g +: 2];
    assign lo = (a < b) ? a : b;
    assign hi = (a < b) ? b : a;

    always_comb begin
      case (base_sel)
        B_MIN:   base = lo;
        B_MAX:   base = hi;
        default: base = a;
      endcase
      case (post_sel)
        P_CMP:   post = ~base;
        P_SWAP:  post = {base[0], base[1]};
        P_INW:   post = {~base[1], base[1]};
        P_OUTW:  post = {~base[1], ~base[1]};
        default: post = base;
      endcase
    end

    assign res_d[2*g +: 2] = legal ? post : 2'd0;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result <= '0;
        bad_op <= 1'b0;
      end else begin
        result <= res_d;
        bad_op <= ~legal;
      end
    end
  end else begin : g_comb
    assign result = res_d;
    assign bad_op = ~legal;
  end

  function automatic bit digits_sym(input logic [W-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < N; i++)
      if (v[2*i +: 2] == 2'd1 || v[2*i +: 2] == 2'd2) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit digits_asym(input logic [W-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < N; i++)
      if (v[2*i +: 2] == 2'd0 || v[2*i +: 2] == 2'd3) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit digits_le(input logic [W-1:0] r, input logic [W-1:0] x);
    bit ok = 1'b1;
    for (int i = 0; i < N; i++)
      if (r[2*i +: 2] > x[2*i +: 2]) ok = 1'b0;
    return ok;
  endfunction

  assert_min_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd0) |-> (digits_le(res_d, op_a) && digits_le(res_d, op_b)));

  assert_max_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd1) |-> (digits_le(op_a, res_d) && digits_le(op_b, res_d)));

  assert_inward_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd4 || op_sel == 4'd8 || op_sel == 4'd9) |-> digits_asym(res_d));

  assert_outward_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd5 || op_sel == 4'd10 || op_sel == 4'd11) |-> digits_sym(res_d));

  assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> (result == '0));
endmodule

// File: tb/qdigit_logic_unit_tb.sv
module qdigit_logic_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [3:0] op_sel = '0;
  logic [W-1:0] result;
  logic bad_op;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qdigit_logic_unit #(.N(N), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .result(result), .bad_op(bad_op)
  );

  function automatic int ref_not(input int x); return 3 - x; endfunction
  function automatic int ref_swap(input int x); return (x % 2) * 2 + x / 2; endfunction
  function automatic int ref_inw(input int x);
    int n = 3 - x;
    if (n == 3) return 2;
    if (n == 0) return 1;
    return n;
  endfunction
  function automatic int ref_outw(input int x);
    int n = 3 - x;
    if (n == 2) return 3;
    if (n == 1) return 0;
    return n;
  endfunction

  function automatic int ref_digit(input int op, input int a, input int b);
    int mn = (a < b) ? a : b;
    int mx = (a < b) ? b : a;
    case (op)
      0: return mn;
      1: return mx;
      2: return ref_not(a);
      3: return ref_swap(a);
      4: return ref_inw(a);
      5: return ref_outw(a);
      6: return ref_swap(mn);
      7: return ref_swap(mx);
      8: return ref_inw(mn);
      9: return ref_inw(mx);
      10: return ref_outw(mn);
      11: return ref_outw(mx);
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; 6, 7: return "R8"; 8, 9: return "R9";
      10, 11: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] s, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_sel = s; op_a = a; op_b = b;
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    op_sel = 4'd1; op_a = '1; op_b = '1;
    repeat (3) @(negedge clk);
    check("R13 reset result", result, '0);
    check("R13 reset flag", {{(W-1){1'b0}}, bad_op}, '0);
    rst_n = 1'b1;

    // R1: digit placement, digit 0 at the low pair, level equals code
    apply(4'd1, {{(W-2){1'b0}}, 2'd3}, '0);
    check("R1 low digit", result, {{(W-2){1'b0}}, 2'd3});
    apply(4'd2, '1, '0);
    check("R1 all digits NOT of 3", result, '0);

    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 16; k++) begin
        logic [W-1:0] a, b, e;
        for (int i = 0; i < N; i++) begin
          int p = (k + i) % 16;
          a[2*i +: 2] = 2'(p / 4);
          b[2*i +: 2] = 2'(p % 4);
          e[2*i +: 2] = 2'(ref_digit(op, p / 4, p % 4));
        end
        apply(4'(op), a, b);
        check(req_of(op), result, e);
        check("R11 flag", {{(W-1){1'b0}}, bad_op}, {{(W-1){1'b0}}, (op >= 12) ? 1'b1 : 1'b0});
        if (op >= 2 && op <= 5) begin
          apply(4'(op), a, ~b);
          check("R12 B ignored", result, e);
        end
      end
    end

    // R13: value appears only after one edge
    @(negedge clk);
    op_sel = 4'd2; op_a = '0; op_b = '0;
    @(posedge clk);
    #1;
    check("R13 one edge latency", result, '1);

    finish_up();
  end
endmodule